// File: doc/BRIEF.md
# Boundary-Run Pattern Engine

This block is a boundary-scan data register whose cells can do more than shift, capture and update. Each cell sits between one device pin and the core. Under the ordinary data instructions the cells snapshot the pins, shift serially from `tdi` to `tdo` and latch new pin drive values. A small control register is written through its own scan instruction and selects an autonomous test operation. The selected operation runs under a dedicated boundary-run instruction, and only while the external TAP controller reports Run-Test/Idle. The operations are:

- a toggle pattern;
- a pseudo-random pattern;
- parallel signature compression of the pin inputs;
- compression combined with a pseudo-random drive;
- compression combined with a counting drive.

The counting drive lets the pins that feed a memory address bus walk through a block of locations without a scan per address.

Two further instructions support checking results and checking the register itself. A read instruction leaves the register untouched in Capture-DR, so a signature can be shifted out. A self-test instruction loads each shift element with the inverse of its update latch. The TAP state machine lies outside the block and reaches it as four state strobes. Shift elements and generators change on the rising TCK edge. Drive latches change on the falling edge.

Top module: `bscan_run_engine`

## Requirements
- R1: Synchronous reset (high, sampled on either edge) clears the control register to operation code 0 (no operation), clears the drive latches to 0, and loads the shift elements and the generator with SEED (default 8'h01).
- R2: Instruction codes are SAMPLE=0, EXTEST=1, RUN=2, READ=3, SELFTEST=4, CONTROL=5, and codes 6 and 7 act as SAMPLE. Under every code except CONTROL, Capture-DR loads `pin_in` (except READ and SELFTEST). Shift-DR moves `tdi` into the top bit with `tdo` equal to bit 0. The falling edge in Update-DR copies the shift elements into the drive latches.
- R3: `pin_out` shows the drive latches under EXTEST and RUN, and shows `sys_out` under all other codes.
- R4: The control register is 3 bits wide and scanned only under CONTROL, where it captures its current value. Its codes are 0 none, 1 toggle, 2 pseudo-random, 3 compress, 4 compress with pseudo-random, and 5 compress with count. Codes 6 and 7 act as none, and under none the pins hold their last value.
- R5: An operation advances only on edges where `st_run_idle` is high and the code is RUN. In any other state or under any other code, the shift elements and the drive do not change except through R2.
- R6: Toggle: on each rising edge the shift elements invert, and on each falling edge their value is copied to the drive.
- R7: Pseudo-random: on each rising edge the shift elements s step to {s[N-2:0], ^(s & M)}, with M = 8'hB8 for N=8. On each falling edge s is copied to the drive.
- R8: Compress: on each rising edge s becomes lfsr(s) XOR `pin_in`, and the drive holds.
- R9: Compress with pseudo-random: s compresses as in R8, and a separate generator g steps as lfsr(g) on each rising edge and is copied to the drive on each falling edge.
- R10: Compress with count: s compresses as in R8, and g increments by one (wrapping) on each rising edge and is copied to the drive on each falling edge. The rising edge in Update-DR loads g from the scanned value, so counting starts at that value.
- R11: Under READ, Capture-DR leaves the shift elements unchanged.
- R12: Under SELFTEST, Capture-DR loads each shift element with the inverse of its drive latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; rising and falling edges both used |
| rst | input | 1 | Synchronous active-high reset |
| ir_code | input | 3 | Current instruction code |
| st_capture_dr | input | 1 | TAP is in Capture-DR |
| st_shift_dr | input | 1 | TAP is in Shift-DR |
| st_update_dr | input | 1 | TAP is in Update-DR |
| st_run_idle | input | 1 | TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pin_in | input | N | Values present at the device pins |
| sys_out | input | N | Functional values from the core |
| pin_out | output | N | Values driven toward the pins |

## Verification
On every cycle the assertions check several step rules in isolation: the one-bit shift, the hold of the shift elements outside Run-Test/Idle, the hold under READ capture, the inverted capture under SELFTEST, the toggle step and the count step. The bench is what shows that whole sequences are right. These are the exact pseudo-random and signature values after several edges, the falling-edge lag between a generator step and the pin drive, and the wrap of the counter. The bench also shows the gating when the wrong instruction sits in Run-Test/Idle.

// File: rtl/bre_pkg.sv
package bre_pkg;

    localparam int OP_W = 3;

    typedef enum logic [2:0] {
        IR_SAMPLE = 3'd0,
        IR_EXTEST = 3'd1,
        IR_RUN    = 3'd2,
        IR_READ   = 3'd3,
        IR_SELF   = 3'd4,
        IR_CTRL   = 3'd5
    } ir_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_TOGGLE    = 3'd1,
        OP_PRPG      = 3'd2,
        OP_PSA       = 3'd3,
        OP_PSA_PRPG  = 3'd4,
        OP_PSA_COUNT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        SR_HOLD, SR_CAPTURE, SR_CAPINV, SR_SHIFT, SR_TOGGLE, SR_LFSR, SR_PSA
    } sr_act_e;

    typedef enum logic [1:0] {
        GEN_HOLD, GEN_LOAD, GEN_LFSR, GEN_INC
    } gen_act_e;

    typedef enum logic [1:0] {
        UPD_HOLD, UPD_FROM_SR, UPD_FROM_GEN
    } upd_act_e;

    typedef struct packed {
        sr_act_e  sr_act;
        gen_act_e gen_act;
        upd_act_e upd_act;
    } cell_ctl_t;

    typedef struct packed {
        logic cap;
        logic shf;
        logic upd;
    } reg_ctl_t;

    // Feedback tap mask, bit k set when stage k feeds the XOR
    function automatic logic [31:0] lfsr_taps(input int unsigned w);
        case (w)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            12:      return 32'h0000_0829;
            16:      return 32'h0000_D008;
            default: return (32'h1 << (w - 1)) | (32'h1 << (w - 2));
        endcase
    endfunction

endpackage

// File: rtl/bre_decode.sv
module bre_decode
    import bre_pkg::*;
(
    input  logic [2:0]      ir_code,
    input  logic            st_capture_dr,
    input  logic            st_shift_dr,
    input  logic            st_update_dr,
    input  logic            st_run_idle,
    input  logic [OP_W-1:0] ctrl_op,
    output cell_ctl_t       cell_ctl,
    output reg_ctl_t        ctrl_ctl,
    output logic            drive_pins,
    output logic            tdo_from_ctrl
);

    logic data_ir;
    logic run;

    always_comb begin
        data_ir       = (ir_code != IR_CTRL);
        run           = st_run_idle && (ir_code == IR_RUN);
        drive_pins    = (ir_code == IR_EXTEST) || (ir_code == IR_RUN);
        tdo_from_ctrl = !data_ir;

        ctrl_ctl.cap = st_capture_dr && !data_ir;
        ctrl_ctl.shf = st_shift_dr && !data_ir;
        ctrl_ctl.upd = st_update_dr && !data_ir;

        cell_ctl.sr_act  = SR_HOLD;
        cell_ctl.gen_act = GEN_HOLD;
        cell_ctl.upd_act = UPD_HOLD;

        if (st_capture_dr && data_ir) begin
            if (ir_code == IR_SELF)
                cell_ctl.sr_act = SR_CAPINV;
            else if (ir_code != IR_READ)
                cell_ctl.sr_act = SR_CAPTURE;
        end else if (st_shift_dr && data_ir) begin
            cell_ctl.sr_act = SR_SHIFT;
        end else if (st_update_dr && data_ir) begin
            cell_ctl.gen_act = GEN_LOAD;
            cell_ctl.upd_act = UPD_FROM_SR;
        end else if (run) begin
            case (ctrl_op)
                OP_TOGGLE: begin
                    cell_ctl.sr_act  = SR_TOGGLE;
                    cell_ctl.upd_act = UPD_FROM_SR;
                end
                OP_PRPG: begin
                    cell_ctl.sr_act  = SR_LFSR;
                    cell_ctl.upd_act = UPD_FROM_SR;
                end
                OP_PSA: begin
                    cell_ctl.sr_act  = SR_PSA;
                end
                OP_PSA_PRPG: begin
                    cell_ctl.sr_act  = SR_PSA;
                    cell_ctl.gen_act = GEN_LFSR;
                    cell_ctl.upd_act = UPD_FROM_GEN;
                end
                OP_PSA_COUNT: begin
                    cell_ctl.sr_act  = SR_PSA;
                    cell_ctl.gen_act = GEN_INC;
                    cell_ctl.upd_act = UPD_FROM_GEN;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bre_ctrl_reg.sv
module bre_ctrl_reg
    import bre_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  reg_ctl_t        ctl,
    input  logic            tdi,
    output logic            ser_out,
    output logic [OP_W-1:0] op_q
);

    logic [OP_W-1:0] shreg;

    always_ff @(posedge tck) begin
        if (rst)
            shreg <= '0;
        else if (ctl.cap)
            shreg <= op_q;
        else if (ctl.shf)
            shreg <= {tdi, shreg[OP_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst)
            op_q <= OP_NONE;
        else if (ctl.upd)
            op_q <= shreg;
    end

    assign ser_out = shreg[0];

endmodule

// File: rtl/bre_cells.sv
module bre_cells
    import bre_pkg::*;
#(
    parameter int N = 8,
    parameter logic [N-1:0] SEED = 1
) (
    input  logic         tck,
    input  logic         rst,
    input  cell_ctl_t    ctl,
    input  logic [N-1:0] pin_in,
    input  logic         tdi,
    output logic [N-1:0] sr_q,
    output logic [N-1:0] gen_q,
    output logic [N-1:0] upd_q
);

    localparam logic [N-1:0] MASK = N'(lfsr_taps(N));

    function automatic logic [N-1:0] lfsr_next(input logic [N-1:0] s);
        return {s[N-2:0], ^(s & MASK)};
    endfunction

    logic [N-1:0] sr_d;
    logic [N-1:0] gen_d;
    logic [N-1:0] upd_d;

    always_comb begin
        case (ctl.sr_act)
            SR_CAPTURE: sr_d = pin_in;
            SR_CAPINV:  sr_d = ~upd_q;
            SR_SHIFT:   sr_d = {tdi, sr_q[N-1:1]};
            SR_TOGGLE:  sr_d = ~sr_q;
            SR_LFSR:    sr_d = lfsr_next(sr_q);
            SR_PSA:     sr_d = lfsr_next(sr_q) ^ pin_in;
            default:    sr_d = sr_q;
        endcase
        case (ctl.gen_act)
            GEN_LOAD: gen_d = sr_q;
            GEN_LFSR: gen_d = lfsr_next(gen_q);
            GEN_INC:  gen_d = gen_q + N'(1);
            default:  gen_d = gen_q;
        endcase
        case (ctl.upd_act)
            UPD_FROM_SR:  upd_d = sr_q;
            UPD_FROM_GEN: upd_d = gen_q;
            default:      upd_d = upd_q;
        endcase
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            sr_q  <= SEED;
            gen_q <= SEED;
        end else begin
            sr_q  <= sr_d;
            gen_q <= gen_d;
        end
    end

    always_ff @(negedge tck) begin
        if (rst)
            upd_q <= '0;
        else
            upd_q <= upd_d;
    end

endmodule

// File: rtl/bscan_run_engine.sv
module bscan_run_engine
    import bre_pkg::*;
#(
    parameter int N = 8,
    parameter logic [N-1:0] SEED = 1
) (
    input  logic         tck,
    input  logic         rst,
    input  logic [2:0]   ir_code,
    input  logic         st_capture_dr,
    input  logic         st_shift_dr,
    input  logic         st_update_dr,
    input  logic         st_run_idle,
    input  logic         tdi,
    output logic         tdo,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] sys_out,
    output logic [N-1:0] pin_out
);

    cell_ctl_t       cell_ctl;
    reg_ctl_t        ctrl_ctl;
    logic            drive_pins;
    logic            tdo_from_ctrl;
    logic            ctrl_ser;
    logic [OP_W-1:0] ctrl_op;
    logic [N-1:0]    sr_q;
    logic [N-1:0]    gen_q;
    logic [N-1:0]    upd_q;

    bre_decode u_decode (
        .ir_code       (ir_code),
        .st_capture_dr (st_capture_dr),
        .st_shift_dr   (st_shift_dr),
        .st_update_dr  (st_update_dr),
        .st_run_idle   (st_run_idle),
        .ctrl_op       (ctrl_op),
        .cell_ctl      (cell_ctl),
        .ctrl_ctl      (ctrl_ctl),
        .drive_pins    (drive_pins),
        .tdo_from_ctrl (tdo_from_ctrl)
    );

    bre_ctrl_reg u_ctrl (
        .tck     (tck),
        .rst     (rst),
        .ctl     (ctrl_ctl),
        .tdi     (tdi),
        .ser_out (ctrl_ser),
        .op_q    (ctrl_op)
    );

    bre_cells #(.N(N), .SEED(SEED)) u_cells (
        .tck    (tck),
        .rst    (rst),
        .ctl    (cell_ctl),
        .pin_in (pin_in),
        .tdi    (tdi),
        .sr_q   (sr_q),
        .gen_q  (gen_q),
        .upd_q  (upd_q)
    );

    assign tdo     = tdo_from_ctrl ? ctrl_ser : sr_q[0];
    assign pin_out = drive_pins ? upd_q : sys_out;

endmodule

// File: rtl/bre_checker.sv
module bre_checker
    import bre_pkg::*;
#(
    parameter int N = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      ir_code,
    input logic            st_capture_dr,
    input logic            st_shift_dr,
    input logic            st_update_dr,
    input logic            st_run_idle,
    input logic            tdi,
    input logic [OP_W-1:0] ctrl_op,
    input logic [N-1:0]    sr_q,
    input logic [N-1:0]    gen_q,
    input logic [N-1:0]    upd_q
);

    logic run;
    assign run = st_run_idle && (ir_code == IR_RUN);

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
        (st_shift_dr && ir_code != IR_CTRL) |=> (sr_q == {$past(tdi), $past(sr_q[N-1:1])}));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!st_run_idle && !st_capture_dr && !st_shift_dr && !st_update_dr) |=> $stable(sr_q));

    assert_toggle_inverts_R6: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl_op == OP_TOGGLE) |=> (sr_q == ~$past(sr_q)));

    assert_count_increments_R10: assert property (@(posedge clk) disable iff (rst)
        (run && ctrl_op == OP_PSA_COUNT) |=> (gen_q == $past(gen_q) + N'(1)));

    assert_read_capture_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (st_capture_dr && ir_code == IR_READ) |=> $stable(sr_q));

    assert_selftest_inverse_R12: assert property (@(posedge clk) disable iff (rst)
        (st_capture_dr && ir_code == IR_SELF) |=> (sr_q == ~$past(upd_q)));

endmodule

bind bscan_run_engine bre_checker #(.N(N)) u_bre_checker (
    .clk           (tck),
    .rst           (rst),
    .ir_code       (ir_code),
    .st_capture_dr (st_capture_dr),
    .st_shift_dr   (st_shift_dr),
    .st_update_dr  (st_update_dr),
    .st_run_idle   (st_run_idle),
    .tdi           (tdi),
    .ctrl_op       (ctrl_op),
    .sr_q          (sr_q),
    .gen_q         (gen_q),
    .upd_q         (upd_q)
);

// File: tb/bscan_run_engine_bench.sv
module bscan_run_engine_bench;

    localparam int N = 8;

    logic         tck = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   ir_code = 3'd0;
    logic         st_capture_dr = 1'b0;
    logic         st_shift_dr = 1'b0;
    logic         st_update_dr = 1'b0;
    logic         st_run_idle = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] sys_out = '0;
    logic [N-1:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 tck = ~tck;

    bscan_run_engine #(.N(N), .SEED(8'h01)) u_bscan_run_engine (
        .tck(tck), .rst(rst), .ir_code(ir_code),
        .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr),
        .st_update_dr(st_update_dr), .st_run_idle(st_run_idle),
        .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .sys_out(sys_out),
        .pin_out(pin_out)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] pre;
        logic [7:0] pins;
        logic [7:0] steps;
    } case_t;

    localparam case_t CASES [7] = '{
        '{3'd1, 8'hA5, 8'h00, 8'd5},
        '{3'd2, 8'h01, 8'h00, 8'd10},
        '{3'd3, 8'h5A, 8'h3C, 8'd8},
        '{3'd4, 8'hC3, 8'h96, 8'd8},
        '{3'd5, 8'hFE, 8'h11, 8'd6},
        '{3'd0, 8'h77, 8'h42, 8'd3},
        '{3'd3, 8'h00, 8'h00, 8'd4}
    };

    function automatic logic [7:0] ref_lfsr(input logic [7:0] s);
        return {s[6:0], ^(s & 8'hB8)};
    endfunction

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic set_st(input logic c, input logic s, input logic u, input logic i);
        st_capture_dr = c;
        st_shift_dr   = s;
        st_update_dr  = u;
        st_run_idle   = i;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [2:0] code, input int len, input logic [15:0] din,
                        output logic [15:0] dout);
        dout = '0;
        ir_code = code;
        set_st(1, 0, 0, 0);
        tick();
        set_st(0, 1, 0, 0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            tick();
        end
        set_st(0, 0, 1, 0);
        tick();
        set_st(0, 0, 0, 0);
    endtask

    task automatic run_case(input case_t c);
        logic [15:0] d;
        logic [7:0]  m_sr, m_gen, m_upd;
        string       tag;
        case (c.op)
            3'd1: tag = "R6";
            3'd2: tag = "R7";
            3'd3: tag = "R8";
            3'd4: tag = "R9";
            3'd5: tag = "R10";
            default: tag = "R4";
        endcase
        scan(3'd5, 3, {13'd0, c.op}, d);
        scan(3'd1, N, {8'd0, c.pre}, d);
        ir_code = 3'd2;
        m_sr = c.pre; m_gen = c.pre; m_upd = c.pre;
        set_st(0, 0, 0, 1);
        for (int t = 0; t < int'(c.steps); t++) begin
            pin_in = c.pins ^ 8'(t * 8'h1D);
            case (c.op)
                3'd1, 3'd2: m_upd = m_sr;
                3'd4, 3'd5: m_upd = m_gen;
                default: ;
            endcase
            case (c.op)
                3'd1: m_sr = ~m_sr;
                3'd2: m_sr = ref_lfsr(m_sr);
                3'd3: m_sr = ref_lfsr(m_sr) ^ pin_in;
                3'd4: begin m_sr = ref_lfsr(m_sr) ^ pin_in; m_gen = ref_lfsr(m_gen); end
                3'd5: begin m_sr = ref_lfsr(m_sr) ^ pin_in; m_gen = m_gen + 8'd1; end
                default: ;
            endcase
            tick();
            check(tag, {8'd0, pin_out}, {8'd0, m_upd});
        end
        set_st(0, 0, 0, 0);
        scan(3'd3, N, 16'd0, d);
        check({tag, "/R11 signature"}, d, {8'd0, m_sr});
    endtask

    initial begin : watchdog
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        sys_out = 8'h3C;
        repeat (3) tick();
        rst = 1'b0;

        // R1: reset state of drive, control and shift elements
        ir_code = 3'd1;
        tick();
        check("R1 drive", {8'd0, pin_out}, 16'h0000);
        scan(3'd5, 3, 16'd0, d);
        check("R1 control", d, 16'h0000);
        scan(3'd3, N, 16'd0, d);
        check("R1 seed", d, 16'h0001);

        // R2/R3: ordinary sample, shift and update
        pin_in = 8'h9E;
        scan(3'd0, N, 16'h006B, d);
        check("R2 capture", d, 16'h009E);
        check("R3 functional", {8'd0, pin_out}, 16'h003C);
        ir_code = 3'd1;
        tick();
        check("R3 extest drive", {8'd0, pin_out}, 16'h006B);

        // R2: unused instruction code acts as sample
        pin_in = 8'h47;
        scan(3'd7, N, 16'd0, d);
        check("R2 code7", d, 16'h0047);

        // R4: control register readback
        scan(3'd5, 3, 16'd4, d);
        scan(3'd5, 3, 16'd0, d);
        check("R4 readback", d, 16'h0004);

        // R5: no advance outside run instruction or outside Run-Test/Idle
        scan(3'd5, 3, 16'd2, d);
        scan(3'd1, N, 16'h0081, d);
        ir_code = 3'd1;
        set_st(0, 0, 0, 1);
        repeat (4) tick();
        check("R5 extest idle", {8'd0, pin_out}, 16'h0081);
        ir_code = 3'd2;
        set_st(0, 0, 0, 0);
        repeat (3) tick();
        check("R5 run paused", {8'd0, pin_out}, 16'h0081);
        scan(3'd3, N, 16'd0, d);
        check("R5 held", d, 16'h0081);

        // R12: self-test captures inverse of drive latch
        scan(3'd1, N, 16'h002D, d);
        scan(3'd4, N, 16'd0, d);
        check("R12 inverse", d, 16'h00D2);
        check("R3 selftest functional", {8'd0, pin_out}, 16'h003C);

        // table of operations
        for (int k = 0; k < 7; k++) begin
            run_case(CASES[k]);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule